// File: doc/BRIEF.md
# Windowed-Carry Speculative Adder

This block adds or subtracts two N-bit operands and delivers the answer twice. The first answer is fast and speculative. Each sum bit is formed from a short ripple chain that only spans the K bits ending at that bit, so no carry ever travels further than K-1 positions. The second answer is the exact sum from a full-length ripple chain. A comparator then reports whether the speculative value was right.

A consumer can start dependent work one cycle after issue using the speculative sum. One cycle later it either confirms that work or, when the mismatch flag is high, replaces the value with the exact sum delivered alongside the flag. Subtraction reuses the same adder by inverting the second operand and forcing the carry-in high. The width N and the window K are parameters. The default is N=8, K=3. To tolerate carry chains of up to x bits, set K to x+1.

The block has no state machine. It is a two-stage pipeline whose stage-valid bits move one position per clock.

Top module: `spec_window_adder`

## Requirements
- R1: While `rst_n` is low, and at the first sample after reset, `spec_valid`, `exact_valid`, `mismatch`, `spec_sum` and `exact_sum` are all zero.
- R2: Speculative bit i equals a[i] XOR b'[i] XOR w[i]. Here b' is the effective second operand and w[i] is the carry out of a ripple chain over bits max(0,i-K+1) to i-1. That chain starts from the carry-in when it begins at bit 0, and from zero otherwise. The carry-in therefore reaches bits 0 to K-1 only.
- R3: Define the distance of a carry arriving at bit i as i-j when it was generated at bit j. A carry that comes from the carry-in has distance i. When every carry that arrives at a sum bit has distance below K, `spec_sum` equals `exact_sum` and `mismatch` is 0.
- R4: When any carry arrives at a sum bit with distance K or more, `mismatch` is 1. Take a generate at bit j followed by 2K-1 propagating bits. The bits j+K to j+2K-1 of the speculative sum are then wrong, and bits j+1 to j+K-1 are right.
- R5: With `sub_sel`=1 the operation is a minus b. b' is the bitwise inverse of b, and the carry-in is 1. `exact_sum` is (a-b) mod 2^N. With `sub_sel`=0, b' is b and the carry-in is 0.
- R6: With `sub_sel`=0, `exact_sum` is (a+b) mod 2^N. The carry out of the top bit is dropped.
- R7: `spec_valid` is high exactly one cycle after the cycle in which `in_valid` was high. `exact_valid` and `mismatch` belong to the cycle after `spec_valid`. Back-to-back operations pipeline with one result per cycle.
- R8: With no valid input, `spec_sum` keeps its value and `spec_valid` is low. With no valid speculative stage, `exact_sum` and `mismatch` keep their values.
- R9: When `exact_valid` is high, `mismatch` is 1 if and only if `exact_sum` differs from the speculative sum that was presented in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands are presented this cycle |
| sub_sel | input | 1 | 1 selects a minus b, 0 selects a plus b |
| op_a | input | N | First operand |
| op_b | input | N | Second operand |
| spec_valid | output | 1 | Speculative sum is new this cycle |
| spec_sum | output | N | Windowed-carry speculative result |
| exact_valid | output | 1 | Exact sum and mismatch flag are new this cycle |
| exact_sum | output | N | Full-carry result |
| mismatch | output | 1 | The speculative result of this operation was wrong |

## Verification
The assertions assume `in_valid` is a single-cycle strobe per operation. They also assume the operands are stable only in the cycle they are sampled. No handshake or back-pressure is assumed, because the block accepts an operation every cycle.

The directed tasks drive the inputs on the falling edge and drop `in_valid` unless a back-to-back case is intended. The operand patterns are chosen so that carry distances fall just below, at and well beyond K, including carries that start from the subtract carry-in. A pseudo-random sweep then compares all three outputs against a reference. That reference finds each carry's origin by walking down from the sum bit, which is a different method from the RTL's windowed ripple.

// File: rtl/swa_pkg.sv
package swa_pkg;

    localparam int unsigned SWA_DEF_WIDTH  = 8;
    localparam int unsigned SWA_DEF_WINDOW = 3;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } swa_op_e;

endpackage

// File: rtl/swa_operand_prep.sv
module swa_operand_prep
    import swa_pkg::*;
#(
    parameter int unsigned WIDTH = SWA_DEF_WIDTH
) (
    input  logic             sub_sel,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_eff,
    output logic             carry_in
);
    swa_op_e op;

    always_comb begin
        op = swa_op_e'(sub_sel);
        unique case (op)
            OP_ADD: begin
                b_eff    = b_in;
                carry_in = 1'b0;
            end
            OP_SUB: begin
                b_eff    = ~b_in;
                carry_in = 1'b1;
            end
            default: begin
                b_eff    = b_in;
                carry_in = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/swa_window_sum.sv
module swa_window_sum
    import swa_pkg::*;
#(
    parameter int unsigned WIDTH  = SWA_DEF_WIDTH,
    parameter int unsigned WINDOW = SWA_DEF_WINDOW
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum
);
    logic [WIDTH-1:0] gen;
    logic [WIDTH-1:0] prop;

    assign gen  = a & b;
    assign prop = a ^ b;

    // Each bit owns a private ripple chain covering the WINDOW-1 bits below it.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        localparam int LO = (i - int'(WINDOW) + 1 > 0) ? (i - int'(WINDOW) + 1) : 0;
        logic win_carry;

        always_comb begin
            win_carry = (LO == 0) ? carry_in : 1'b0;
            for (int j = LO; j < i; j++) begin
                win_carry = gen[j] | (prop[j] & win_carry);
            end
        end

        assign sum[i] = prop[i] ^ win_carry;
    end
endmodule

// File: rtl/swa_ripple_sum.sv
module swa_ripple_sum
    import swa_pkg::*;
#(
    parameter int unsigned WIDTH = SWA_DEF_WIDTH
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum
);
    logic [WIDTH:0] chain;

    always_comb begin
        chain[0] = carry_in;
        for (int j = 0; j < int'(WIDTH); j++) begin
            sum[j]     = a[j] ^ b[j] ^ chain[j];
            chain[j+1] = (a[j] & b[j]) | ((a[j] ^ b[j]) & chain[j]);
        end
    end
endmodule

// File: rtl/spec_window_adder.sv
module spec_window_adder
    import swa_pkg::*;
#(
    parameter int unsigned WIDTH  = SWA_DEF_WIDTH,
    parameter int unsigned WINDOW = SWA_DEF_WINDOW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             sub_sel,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic             spec_valid,
    output logic [WIDTH-1:0] spec_sum,
    output logic             exact_valid,
    output logic [WIDTH-1:0] exact_sum,
    output logic             mismatch
);
    logic [WIDTH-1:0] b_eff;
    logic             cin;
    logic [WIDTH-1:0] win_sum;

    // Stage-one record: speculative value plus the operands kept for the exact pass.
    logic             s1_valid;
    logic [WIDTH-1:0] s1_spec;
    logic [WIDTH-1:0] s1_a;
    logic [WIDTH-1:0] s1_b;
    logic             s1_cin;

    logic [WIDTH-1:0] full_sum;
    logic             s2_valid;
    logic [WIDTH-1:0] s2_exact;
    logic             s2_miss;

    swa_operand_prep #(.WIDTH(WIDTH)) u_prep (
        .sub_sel  (sub_sel),
        .b_in     (op_b),
        .b_eff    (b_eff),
        .carry_in (cin)
    );

    swa_window_sum #(.WIDTH(WIDTH), .WINDOW(WINDOW)) u_window (
        .a        (op_a),
        .b        (b_eff),
        .carry_in (cin),
        .sum      (win_sum)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_spec  <= '0;
            s1_a     <= '0;
            s1_b     <= '0;
            s1_cin   <= 1'b0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_spec <= win_sum;
                s1_a    <= op_a;
                s1_b    <= b_eff;
                s1_cin  <= cin;
            end
        end
    end

    swa_ripple_sum #(.WIDTH(WIDTH)) u_exact (
        .a        (s1_a),
        .b        (s1_b),
        .carry_in (s1_cin),
        .sum      (full_sum)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_exact <= '0;
            s2_miss  <= 1'b0;
        end else begin
            s2_valid <= s1_valid;
            if (s1_valid) begin
                s2_exact <= full_sum;
                s2_miss  <= (full_sum != s1_spec);
            end
        end
    end

    assign spec_valid  = s1_valid;
    assign spec_sum    = s1_spec;
    assign exact_valid = s2_valid;
    assign exact_sum   = s2_exact;
    assign mismatch    = s2_miss;

    a_r7_spec_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> spec_valid);

    a_r7_exact_latency: assert property (@(posedge clk) disable iff (!rst_n)
        spec_valid |=> exact_valid);

    a_r7_exact_needs_spec: assert property (@(posedge clk) disable iff (!rst_n)
        exact_valid |-> $past(spec_valid));

    a_r8_spec_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(spec_sum));

    a_r8_exact_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !spec_valid |=> ($stable(exact_sum) && $stable(mismatch)));

    a_r9_flag_matches: assert property (@(posedge clk) disable iff (!rst_n)
        exact_valid |-> (mismatch == (exact_sum != $past(spec_sum))));
endmodule

// File: tb/spec_window_adder_bench.sv
module spec_window_adder_bench;
    localparam int N = 8;
    localparam int K = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         sub_sel = 1'b0;
    logic [N-1:0] op_a = '0;
    logic [N-1:0] op_b = '0;
    logic         spec_valid;
    logic [N-1:0] spec_sum;
    logic         exact_valid;
    logic [N-1:0] exact_sum;
    logic         mismatch;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    spec_window_adder #(.WIDTH(N), .WINDOW(K)) u_spec_window_adder (
        .clk, .rst_n, .in_valid, .sub_sel, .op_a, .op_b,
        .spec_valid, .spec_sum, .exact_valid, .exact_sum, .mismatch
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference: find each carry's origin by walking down from the sum bit.
    task automatic ref_eval(input logic [N-1:0] a, input logic [N-1:0] b, input bit sub,
                            output logic [N-1:0] spec, output logic [N-1:0] exact,
                            output bit flag);
        logic [N-1:0] be;
        be   = sub ? ~b : b;
        flag = 0;
        exact = N'(a + be + N'(sub));
        for (int i = 0; i < N; i++) begin
            bit c = 0;
            int d = 0;
            bit found = 0;
            for (int j = i - 1; j >= 0; j--) begin
                if (!found) begin
                    if (a[j] & be[j]) begin c = 1; d = i - j; found = 1; end
                    else if (!(a[j] ^ be[j])) begin c = 0; found = 1; end
                end
            end
            if (!found) begin c = sub; d = i; end
            spec[i] = a[i] ^ be[i] ^ (c && d < K);
            if (c && d >= K) flag = 1;
        end
    endtask

    task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b, input bit sub,
                          input string tag);
        logic [N-1:0] es, ee;
        bit ef;
        ref_eval(a, b, sub, es, ee, ef);
        @(negedge clk);
        op_a = a; op_b = b; sub_sel = sub; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(spec_valid == 1'b1, {tag, " R7 spec_valid"}, spec_valid, 1);
        check(spec_sum == es, {tag, " R2 spec_sum"}, spec_sum, es);
        @(negedge clk);
        check(spec_valid == 1'b0 && exact_valid == 1'b1, {tag, " R7 exact_valid"}, exact_valid, 1);
        check(exact_sum == ee, {tag, " R5 R6 exact_sum"}, exact_sum, ee);
        check(mismatch == ef, {tag, " R9 mismatch"}, mismatch, ef);
        check(spec_sum == es, {tag, " R8 spec hold"}, spec_sum, es);
    endtask

    task automatic t_reset();
        check(spec_valid == 0 && exact_valid == 0 && mismatch == 0, "R1 strobes", 0, 0);
        check(spec_sum == 0 && exact_sum == 0, "R1 sums", spec_sum, 0);
    endtask

    task automatic t_fixed();
        run_op(8'h12, 8'h21, 0, "R3 no carry");
        check(exact_sum == 8'h33 && mismatch == 0, "R3 R6 no carry value", exact_sum, 8'h33);
        run_op(8'h03, 8'h01, 0, "R3 dist K-1");
        check(spec_sum == 8'h04 && mismatch == 0, "R3 dist K-1 value", spec_sum, 8'h04);
        run_op(8'h07, 8'h01, 0, "R4 dist K");
        check(spec_sum == 8'h00 && mismatch == 1, "R4 dist K value", spec_sum, 8'h00);
        run_op(8'h3F, 8'h01, 0, "R4 2K chain");
        check((spec_sum ^ exact_sum) == 8'h78, "R4 2K wrong bits", spec_sum ^ exact_sum, 8'h78);
        run_op(8'h80, 8'h80, 0, "R6 top carry dropped");
        check(exact_sum == 8'h00 && mismatch == 0, "R6 top carry value", exact_sum, 0);
        run_op(8'h05, 8'h03, 1, "R5 sub 5-3");
        check(exact_sum == 8'h02 && spec_sum == 8'hE2, "R5 sub 5-3 value", spec_sum, 8'hE2);
        run_op(8'h00, 8'h00, 1, "R2 cin window");
        check(spec_sum == 8'hF8 && exact_sum == 8'h00, "R2 cin reaches bits 0..K-1", spec_sum, 8'hF8);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        op_a = 8'h01; op_b = 8'h01; sub_sel = 0; in_valid = 1;
        @(negedge clk);
        check(spec_sum == 8'h02, "R7 b2b first spec", spec_sum, 8'h02);
        op_a = 8'h0F; op_b = 8'h01; sub_sel = 0;
        @(negedge clk);
        in_valid = 0;
        check(spec_valid && exact_valid, "R7 b2b both strobes", {spec_valid, exact_valid}, 3);
        check(exact_sum == 8'h02 && mismatch == 0, "R7 b2b first exact", exact_sum, 8'h02);
        check(spec_sum == 8'h08, "R7 b2b second spec", spec_sum, 8'h08);
        @(negedge clk);
        check(exact_sum == 8'h10 && mismatch == 1, "R7 b2b second exact", exact_sum, 8'h10);
        @(negedge clk);
        check(!exact_valid && exact_sum == 8'h10 && mismatch == 1, "R8 exact hold", exact_sum, 8'h10);
    endtask

    task automatic t_sweep();
        for (int n = 0; n < 300; n++) begin
            logic [N-1:0] es, ee;
            bit ef;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ref_eval(lfsr[7:0], lfsr[15:8], lfsr[3], es, ee, ef);
            @(negedge clk);
            op_a = lfsr[7:0]; op_b = lfsr[15:8]; sub_sel = lfsr[3]; in_valid = 1;
            @(negedge clk);
            in_valid = 0;
            check(spec_sum == es, "R2 R3 sweep spec", spec_sum, es);
            @(negedge clk);
            check(exact_sum == ee, "R5 R6 sweep exact", exact_sum, ee);
            check(mismatch == ef, "R4 sweep flag", mismatch, ef);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fixed();
        t_back_to_back();
        t_sweep();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule